// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Bus Monitor

This block listens passively to a three-wire synchronous serial bus with an active-high select line, a serial clock, a controller-to-peripheral data line and a peripheral-to-controller data line. A system clock that runs much faster than the serial clock oversamples all four lines. The block never drives the bus.

Each select window is classified as either a data transfer or a ready/busy poll. A transfer needs a clock rising edge, and the controller data line must be high at the first one. In a transfer the first bit is the start bit. Every later bit is reported as a one-cycle record. The record pairs the controller bit taken on a rising clock edge with the peripheral bit taken on the next falling edge. During a poll, a level output follows the peripheral line: high means ready and low means busy. When select drops, a frame-done strobe reports the class of the window and the number of data bits it carried.

Top module: `mw_monitor`

## Requirements
- R1: An active-low synchronous reset, applied at any time (including mid-window), returns the monitor to idle. All strobes and both status levels are then low, and no window is in progress.
- R2: A rising edge of the select line opens a window. Its falling edge closes the window and gives exactly one `frame_done_o` strobe.
- R3: If the clock is high when select rises, `warn_clk_high_o` pulses once. The clock is then treated as low, so its next falling edge is ignored and its next rising edge opens the first bit.
- R4: When the controller line is 1 at the first rising clock edge, the window is a transfer. That bit is the start bit and is reported only by `start_valid_o` when it closes, never by `bit_valid_o`.
- R5: Each data bit is reported by a `bit_valid_o` pulse when the next rising clock edge arrives. `bit_si_o` is the controller line at the bit's opening rising edge. `bit_so_o` is the peripheral line at the falling edge that follows it.
- R6: In a transfer, if select falls while the clock is low, the open bit is closed and reported in the same cycle as `frame_done_o`. If select falls while the clock is high, the open bit is dropped.
- R7: A window is a poll (`frame_is_status_o` = 1 with `frame_done_o`) when it has no rising clock edge, or when the controller line is 0 at the first rising edge. The second case also pulses `warn_start_low_o`, and all later clock edges in that window are ignored.
- R8: `status_active_o` is high while a window is open and not yet classified as a transfer. `status_ready_o` is the peripheral line level qualified by `status_active_o`: 1 means ready, 0 means busy.
- R9: `bit_count_o` is valid with `frame_done_o`. It gives the number of data bits reported in the window, not counting the start bit. It is 0 for a poll and saturates at 2^CNT_W-1.
- R10: Clock and data activity while select is low produces no strobe of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Bus select line, active high |
| sk_i | input | 1 | Bus serial clock |
| si_i | input | 1 | Controller-to-peripheral data |
| so_i | input | 1 | Peripheral-to-controller data |
| bit_valid_o | output | 1 | Strobe: one data bit record |
| bit_si_o | output | 1 | Controller bit of the record |
| bit_so_o | output | 1 | Peripheral bit of the record |
| start_valid_o | output | 1 | Strobe: start bit closed |
| warn_clk_high_o | output | 1 | Strobe: clock high when select rose |
| warn_start_low_o | output | 1 | Strobe: controller line low at first rising clock |
| frame_done_o | output | 1 | Strobe: window closed |
| frame_is_status_o | output | 1 | Window was a poll, valid with frame_done_o |
| bit_count_o | output | CNT_W | Data bits in the window, valid with frame_done_o |
| status_active_o | output | 1 | Window open and not a transfer |
| status_ready_o | output | 1 | Ready level during a poll |

## Verification
The bench opens a window with the clock already high. A design that does not treat the clock as low would take the stray falling edge as a peripheral sample or lose the first bit. The bench closes windows both with the clock low and with it high, which shows whether the trailing bit is emitted or dropped, and it checks a single-bit window in which the start bit is closed by select alone. It also covers polls with no clock edges, polls marked by a low first controller bit (a design that keeps decoding would emit stray records), a run long enough to saturate a narrow counter (a wrapping counter would report a small value), bus activity while deselected, and a reset that hits an open window.

// File: rtl/mw_pkg.sv
package mw_pkg;
    // Positions of the bus lines inside the synchroniser vector
    localparam int LN_CS = 0;
    localparam int LN_SK = 1;
    localparam int LN_SI = 2;
    localparam int LN_SO = 3;
    localparam int N_LINES = 4;
    // Lines that need edge detection: select and serial clock
    localparam int N_EDGE = 2;
    localparam int ED_CS = 0;
    localparam int ED_SK = 1;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int NL     = 4,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] raw_i,
    output logic [NL-1:0] lvl_o
);
    localparam int TOP = STAGES - 1;

    for (genvar g = 0; g < NL; g++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_i[g]};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign lvl_o[g] = chain_q[TOP];
    end
endmodule

// File: rtl/mw_edge.sv
module mw_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
        fall_o = ~lvl_i & prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/mw_framer.sv
module mw_framer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_rise,
    input  logic             cs_fall,
    input  logic             sk_lvl,
    input  logic             sk_rise,
    input  logic             sk_fall,
    input  logic             si_lvl,
    input  logic             so_lvl,
    output logic             bit_valid,
    output logic             bit_si,
    output logic             bit_so,
    output logic             start_valid,
    output logic             warn_clk,
    output logic             warn_start,
    output logic             done,
    output logic             done_status,
    output logic [CNT_W-1:0] cnt_out,
    output logic             stat_act,
    output logic             stat_rdy
);
    typedef struct packed {
        logic             in_frame;
        logic             xfer;
        logic             seen_rise;
        logic             start_pend;
        logic             have_bit;
        logic             cur_si;
        logic             cur_so;
        logic [CNT_W-1:0] cnt;
        logic             bit_valid;
        logic             bit_si;
        logic             bit_so;
        logic             start_valid;
        logic             warn_clk;
        logic             warn_start;
        logic             done;
        logic             done_status;
        logic [CNT_W-1:0] cnt_out;
        logic             stat_act;
        logic             stat_rdy;
    } fr_t;

    fr_t d, q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = (&q.cnt) ? q.cnt : q.cnt + 1'b1;

        d             = q;
        d.bit_valid   = 1'b0;
        d.start_valid = 1'b0;
        d.warn_clk    = 1'b0;
        d.warn_start  = 1'b0;
        d.done        = 1'b0;

        if (cs_rise) begin
            // Open a window; a high clock here counts as low
            d.in_frame    = 1'b1;
            d.xfer        = 1'b0;
            d.seen_rise   = 1'b0;
            d.start_pend  = 1'b1;
            d.have_bit    = 1'b0;
            d.cur_si      = 1'b0;
            d.cur_so      = 1'b0;
            d.cnt         = '0;
            d.done_status = 1'b0;
            d.warn_clk    = sk_lvl;
        end else if (q.in_frame && cs_fall) begin
            d.in_frame    = 1'b0;
            d.done        = 1'b1;
            d.done_status = !q.xfer;
            if (q.xfer && q.have_bit && !sk_lvl) begin
                if (q.start_pend) begin
                    d.start_valid = 1'b1;
                    d.start_pend  = 1'b0;
                end else begin
                    d.bit_valid = 1'b1;
                    d.bit_si    = q.cur_si;
                    d.bit_so    = q.cur_so;
                    d.cnt       = cnt_inc;
                end
            end
            d.cnt_out = d.cnt;
        end else if (q.in_frame) begin
            if (sk_rise) begin
                if (!q.seen_rise) begin
                    // Classification point of the window
                    d.seen_rise = 1'b1;
                    if (si_lvl) begin
                        d.xfer     = 1'b1;
                        d.have_bit = 1'b1;
                        d.cur_si   = 1'b1;
                    end else begin
                        d.warn_start = 1'b1;
                    end
                end else if (q.xfer) begin
                    if (q.start_pend) begin
                        d.start_valid = 1'b1;
                        d.start_pend  = 1'b0;
                    end else begin
                        d.bit_valid = 1'b1;
                        d.bit_si    = q.cur_si;
                        d.bit_so    = q.cur_so;
                        d.cnt       = cnt_inc;
                    end
                    d.cur_si = si_lvl;
                end
            end else if (sk_fall && q.xfer) begin
                d.cur_so = so_lvl;
            end
        end

        d.stat_act = d.in_frame && !d.xfer;
        d.stat_rdy = d.stat_act && so_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_valid   = q.bit_valid;
    assign bit_si      = q.bit_si;
    assign bit_so      = q.bit_so;
    assign start_valid = q.start_valid;
    assign warn_clk    = q.warn_clk;
    assign warn_start  = q.warn_start;
    assign done        = q.done;
    assign done_status = q.done_status;
    assign cnt_out     = q.cnt_out;
    assign stat_act    = q.stat_act;
    assign stat_rdy    = q.stat_rdy;

    // R2
    done_on_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && q.in_frame && !cs_rise) |=> q.done);

    // R3
    warn_clk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.warn_clk |-> $past(cs_rise && sk_lvl));

    // R7
    poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.done_status) |-> (!q.bit_valid && !q.start_valid));

    // R8
    ready_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.stat_rdy |-> q.stat_act);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.in_frame && !cs_rise) |=> (!q.bit_valid && !q.start_valid && !q.warn_start));
endmodule

// File: rtl/mw_monitor.sv
module mw_monitor #(
    parameter int CNT_W  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_i,
    input  logic             sk_i,
    input  logic             si_i,
    input  logic             so_i,
    output logic             bit_valid_o,
    output logic             bit_si_o,
    output logic             bit_so_o,
    output logic             start_valid_o,
    output logic             warn_clk_high_o,
    output logic             warn_start_low_o,
    output logic             frame_done_o,
    output logic             frame_is_status_o,
    output logic [CNT_W-1:0] bit_count_o,
    output logic             status_active_o,
    output logic             status_ready_o
);
    import mw_pkg::*;

    logic [N_LINES-1:0] raw, lvl;
    logic [N_EDGE-1:0]  e_lvl, e_rise, e_fall;

    always_comb begin
        raw        = '0;
        raw[LN_CS] = cs_i;
        raw[LN_SK] = sk_i;
        raw[LN_SI] = si_i;
        raw[LN_SO] = so_i;
        e_lvl         = '0;
        e_lvl[ED_CS]  = lvl[LN_CS];
        e_lvl[ED_SK]  = lvl[LN_SK];
    end

    mw_sync #(.NL(N_LINES), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw),
        .lvl_o (lvl)
    );

    mw_edge #(.W(N_EDGE)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (e_lvl),
        .rise_o (e_rise),
        .fall_o (e_fall)
    );

    mw_framer #(.CNT_W(CNT_W)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_rise     (e_rise[ED_CS]),
        .cs_fall     (e_fall[ED_CS]),
        .sk_lvl      (lvl[LN_SK]),
        .sk_rise     (e_rise[ED_SK]),
        .sk_fall     (e_fall[ED_SK]),
        .si_lvl      (lvl[LN_SI]),
        .so_lvl      (lvl[LN_SO]),
        .bit_valid   (bit_valid_o),
        .bit_si      (bit_si_o),
        .bit_so      (bit_so_o),
        .start_valid (start_valid_o),
        .warn_clk    (warn_clk_high_o),
        .warn_start  (warn_start_low_o),
        .done        (frame_done_o),
        .done_status (frame_is_status_o),
        .cnt_out     (bit_count_o),
        .stat_act    (status_active_o),
        .stat_rdy    (status_ready_o)
    );
endmodule

// File: tb/sim_mw_monitor.sv
`timescale 1ns/1ps
module sim_mw_monitor;
    localparam int CW = 4;
    localparam int K_WCLK = 0, K_WSTART = 1, K_START = 2, K_BIT = 3, K_DONE = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, si = 1'b0, so = 1'b0;
    logic bit_valid, bit_si, bit_so, start_valid, warn_clk, warn_start;
    logic frame_done, frame_status, st_active, st_ready;
    logic [CW-1:0] bit_count;

    always #2.5 clk = ~clk;

    mw_monitor #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .si_i(si), .so_i(so),
        .bit_valid_o(bit_valid), .bit_si_o(bit_si), .bit_so_o(bit_so),
        .start_valid_o(start_valid), .warn_clk_high_o(warn_clk),
        .warn_start_low_o(warn_start), .frame_done_o(frame_done),
        .frame_is_status_o(frame_status), .bit_count_o(bit_count),
        .status_active_o(st_active), .status_ready_o(st_ready)
    );

    typedef struct {
        int    kind;
        logic  si;
        logic  so;
        logic  st;
        int    cnt;
        string req;
    } item_t;

    item_t exp_q[$];
    int checks = 0, fails = 0;
    bit ended = 1'b0;

    task automatic finish_up();
        ended = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    task automatic push(int k, logic a, logic b, logic st, int c, string r);
        item_t it;
        it.kind = k; it.si = a; it.so = b; it.st = st; it.cnt = c; it.req = r;
        exp_q.push_back(it);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic check_pop(int k, logic a, logic b, logic st, int c);
        item_t it;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R10 unexpected output: actual kind %0d expected none", k);
            return;
        end
        it = exp_q.pop_front();
        if (it.kind != k || (k == K_BIT && (it.si !== a || it.so !== b)) ||
            (k == K_DONE && (it.st !== st || it.cnt != c))) begin
            fails++;
            $display("FAIL %s: actual kind=%0d si=%0b so=%0b status=%0b count=%0d expected kind=%0d si=%0b so=%0b status=%0b count=%0d",
                     it.req, k, a, b, st, c, it.kind, it.si, it.so, it.st, it.cnt);
        end
    endtask

    // Monitor: pops and compares on every output strobe, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            if (warn_clk)    check_pop(K_WCLK, 1'b0, 1'b0, 1'b0, 0);
            if (warn_start)  check_pop(K_WSTART, 1'b0, 1'b0, 1'b0, 0);
            if (start_valid) check_pop(K_START, 1'b0, 1'b0, 1'b0, 0);
            if (bit_valid)   check_pop(K_BIT, bit_si, bit_so, 1'b0, 0);
            if (frame_done)  check_pop(K_DONE, 1'b0, 1'b0, frame_status, int'(bit_count));
        end
    end

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one select window of n clocked bits
    task automatic run_frame(int n, logic [31:0] si_v, logic [31:0] so_v, bit clk_hi, bit end_hi);
        int maxc;
        maxc = (1 << CW) - 1;
        if (clk_hi) push(K_WCLK, 1'b0, 1'b0, 1'b0, 0, "R3");
        if (n == 0) begin
            push(K_DONE, 1'b0, 1'b0, 1'b1, 0, "R7");
        end else if (!si_v[0]) begin
            push(K_WSTART, 1'b0, 1'b0, 1'b0, 0, "R7");
            push(K_DONE, 1'b0, 1'b0, 1'b1, 0, "R7");
        end else begin
            push(K_START, 1'b0, 1'b0, 1'b0, 0, "R4");
            for (int i = 1; i < n; i++)
                push(K_BIT, si_v[i], so_v[i], 1'b0, 0, (i == n - 1 && !end_hi) ? "R6" : "R5");
            push(K_DONE, 1'b0, 1'b0, 1'b0, ((n - 1) > maxc) ? maxc : (n - 1), "R9");
        end
        sk = clk_hi; cs = 1'b1;
        hold(4);
        if (clk_hi) begin sk = 1'b0; hold(4); end
        for (int i = 0; i < n; i++) begin
            si = si_v[i]; hold(2);
            sk = 1'b1;    hold(4);
            so = so_v[i]; hold(2);
            sk = 1'b0;    hold(4);
        end
        if (end_hi) begin si = 1'b1; sk = 1'b1; hold(4); end
        cs = 1'b0; hold(6);
        sk = 1'b0; si = 1'b0; so = 1'b0; hold(8);
    endtask

    task automatic status_poll();
        push(K_DONE, 1'b0, 1'b0, 1'b1, 0, "R7");
        so = 1'b0; cs = 1'b1; hold(6);
        chk(st_active === 1'b1, "R8", "status_active during poll", st_active, 1);
        chk(st_ready === 1'b0, "R8", "busy level", st_ready, 0);
        so = 1'b1; hold(6);
        chk(st_ready === 1'b1, "R8", "ready level", st_ready, 1);
        so = 1'b0; hold(6);
        chk(st_ready === 1'b0, "R8", "busy again", st_ready, 0);
        so = 1'b1; hold(4);
        cs = 1'b0; hold(6);
        chk(st_active === 1'b0, "R8", "status_active after close", st_active, 0);
        so = 1'b0; hold(6);
    endtask

    initial begin
        hold(5);
        chk({bit_valid, start_valid, warn_clk, warn_start, frame_done, st_active, st_ready} == 7'd0,
            "R1", "outputs in reset", 0, 0);
        rst_n = 1'b1;
        hold(4);
        chk({bit_valid, start_valid, frame_done, st_active, st_ready} == 5'd0,
            "R1", "outputs after reset", 0, 0);

        run_frame(5, 32'b01101, 32'b10110, 1'b0, 1'b0);   // R5 R6
        run_frame(4, 32'b1001, 32'b0110, 1'b1, 1'b0);     // R3
        run_frame(3, 32'b111, 32'b011, 1'b0, 1'b1);       // R6 clock high at close
        run_frame(1, 32'b1, 32'b0, 1'b0, 1'b0);           // R4 start closed by select
        run_frame(0, 32'b0, 32'b0, 1'b0, 1'b0);           // R7 no clock
        run_frame(3, 32'b110, 32'b111, 1'b0, 1'b0);       // R7 low first bit
        status_poll();                                    // R8

        // R10: bus activity while deselected
        for (int i = 0; i < 6; i++) begin
            sk = 1'b1; si = i[0]; so = ~i[0]; hold(3);
            sk = 1'b0; hold(3);
        end
        si = 1'b0; so = 1'b0; hold(8);
        chk(exp_q.size() == 0, "R10", "pending items after idle noise", exp_q.size(), 0);

        run_frame(20, 32'h55555, 32'hAAAAA, 1'b0, 1'b0);  // R9 saturation

        // R1: reset in the middle of an open window
        cs = 1'b1; hold(6);
        chk(st_active === 1'b1, "R8", "status_active before reset", st_active, 1);
        rst_n = 1'b0; cs = 1'b0; hold(3);
        chk(st_active === 1'b0, "R1", "status_active in mid-window reset", st_active, 0);
        chk(frame_done === 1'b0, "R1", "frame_done in reset", frame_done, 0);
        rst_n = 1'b1; hold(6);
        chk({bit_valid, start_valid, frame_done, st_active} == 4'd0,
            "R1", "idle after mid-window reset", 0, 0);

        run_frame(2, 32'b11, 32'b10, 1'b0, 1'b0);         // R2 recovery after reset
        hold(10);
        chk(exp_q.size() == 0, "R2", "expected items left over", exp_q.size(), 0);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_up();
        end
    end
endmodule